// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is the iterative arithmetic unit of a 32-bit integer core that owns the two result registers HI and LO. A start pulse comes with a 6-bit function code and two operands. The function code selects one of four operations: signed multiply, unsigned multiply, signed divide or unsigned divide. The unit then works for a fixed number of cycles and raises `busy` while it does.

A multiply uses a radix-2 shift-add loop, and a divide uses a restoring loop. Both loops work on operand magnitudes. A final fix-up cycle applies the sign and writes HI and LO together.

A combinational read port serves move-from-HI and move-from-LO requests. It always returns the last completed result. When a read arrives while an operation is running, the port raises `mf_stall` so that the surrounding pipeline can hold the read until the result lands.

Top module: `hilo_muldiv`

## Requirements
- R1: Signed multiply (function 011000) treats both operands as two's complement. HI receives bits 63..32 of the 64-bit product and LO receives bits 31..0.
- R2: Unsigned multiply (function 011001) treats both operands as unsigned and uses the same HI/LO split as R1.
- R3: Signed divide (function 011010) places the quotient, truncated toward zero, in LO. It places the remainder in HI, and the remainder carries the sign of the dividend. The case -2^31 / -1 yields quotient 0x80000000 and remainder 0.
- R4: Unsigned divide (function 011011) places the unsigned quotient in LO and the unsigned remainder in HI.
- R5: A divide with a zero divisor completes in the normal time. It leaves 0xFFFFFFFF in LO and the unchanged dividend in HI.
- R6: An accepted start makes `busy` high from the next cycle on for exactly 33 cycles: 32 iterations and one fix-up. HI and LO hold the new result in the first cycle after `busy` falls.
- R7: A start pulse that arrives while `busy` is high is ignored. The running operation's result and duration are unchanged.
- R8: While `busy` is high, HI and LO reads return the previous completed result, and `mf_stall` equals `mf_req`. While `busy` is low, `mf_stall` is 0.
- R9: `mf_data` returns HI for read code 010000 and LO for read code 010010. It returns 0 for any other code.
- R10: A start whose function code is not one of the four operations is ignored. `busy` stays low and HI/LO are unchanged.
- R11: After reset, HI and LO are 0 and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse for an operation |
| func | input | 6 | Operation function code |
| rs_val | input | 32 | First operand (multiplicand / dividend) |
| rt_val | input | 32 | Second operand (multiplier / divisor) |
| mf_req | input | 1 | A move-from-HI/LO read is being made |
| mf_func | input | 6 | Read code selecting HI or LO |
| mf_data | output | 32 | Selected result register |
| mf_stall | output | 1 | Read must wait for the running operation |
| busy | output | 1 | Operation in progress |

## Verification
The assertions watch, on every cycle:
- that an accepted start raises `busy`;
- that HI and LO change only in the fix-up cycle;
- that a start during a run leaves the latched divisor or multiplicand alone;
- that `mf_stall` is never raised while the unit is idle;
- that a zero divisor yields an all-ones quotient.

Only the bench's scenarios can show that the arithmetic itself is right. These include the signed truncation and remainder-sign rules, the most-negative-by-minus-one corner, the exact 33-cycle duration, and the values read back during a run.

// File: rtl/hilo_muldiv.sv
module hilo_muldiv #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [5:0]   func,
  input  logic [W-1:0] rs_val,
  input  logic [W-1:0] rt_val,
  input  logic         mf_req,
  input  logic [5:0]   mf_func,
  output logic [W-1:0] mf_data,
  output logic         mf_stall,
  output logic         busy
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [5:0] RD_HI = 6'b010000;
  localparam logic [5:0] RD_LO = 6'b010010;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIX} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [W:0]    acc;
  logic [W-1:0]  qb;
  logic [W-1:0]  mreg;
  logic          is_div, neg_p, neg_r, dz;
  logic [W-1:0]  hi_q, lo_q;

  wire is_md = (func[5:2] == 4'b0110);
  wire go    = start && (st == S_IDLE) && is_md;
  wire sgn   = ~func[0];
  wire a_neg = sgn & rs_val[W-1];
  wire b_neg = sgn & rt_val[W-1];
  wire [W-1:0] abs_a = a_neg ? -rs_val : rs_val;
  wire [W-1:0] abs_b = b_neg ? -rt_val : rt_val;

  wire [W:0]   msum  = {1'b0, acc[W-1:0]} + (qb[0] ? {1'b0, mreg} : '0);
  wire [W:0]   shl   = {acc[W-1:0], qb[W-1]};
  wire [W+1:0] diff  = {1'b0, shl} - {2'b0, mreg};
  wire         borrow = diff[W+1];

  wire [2*W-1:0] prod   = {acc[W-1:0], qb};
  wire [2*W-1:0] prod_s = neg_p ? -prod : prod;
  wire [W-1:0]   quo_s  = dz ? '1 : (neg_p ? -qb : qb);
  wire [W-1:0]   rem_s  = neg_r ? -acc[W-1:0] : acc[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; acc <= '0; qb <= '0; mreg <= '0;
      is_div <= 1'b0; neg_p <= 1'b0; neg_r <= 1'b0; dz <= 1'b0;
      hi_q <= '0; lo_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          st     <= S_RUN;
          cnt    <= '0;
          acc    <= '0;
          is_div <= func[1];
          neg_p  <= a_neg ^ b_neg;
          neg_r  <= a_neg;
          dz     <= (rt_val == '0);
          if (func[1]) begin
            qb <= abs_a; mreg <= abs_b;
          end else begin
            qb <= abs_b; mreg <= abs_a;
          end
        end
        S_RUN: begin
          if (is_div) begin
            if (!borrow) begin
              acc <= diff[W:0];
              qb  <= {qb[W-2:0], 1'b1};
            end else begin
              acc <= shl;
              qb  <= {qb[W-2:0], 1'b0};
            end
          end else begin
            acc <= {1'b0, msum[W:1]};
            qb  <= {msum[0], qb[W-1:1]};
          end
          cnt <= cnt + 1'b1;
          if (cnt == LAST) st <= S_FIX;
        end
        S_FIX: begin
          if (is_div) begin
            lo_q <= quo_s;
            hi_q <= rem_s;
          end else begin
            hi_q <= prod_s[2*W-1:W];
            lo_q <= prod_s[W-1:0];
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign mf_stall = mf_req & busy;
  assign mf_data  = (mf_func == RD_HI) ? hi_q :
                    (mf_func == RD_LO) ? lo_q : '0;

  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && is_md) |=> busy); // R6
  AST_HILO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_FIX) |=> ($stable(hi_q) && $stable(lo_q))); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st == S_RUN) |=> $stable(mreg)); // R7
  AST_NO_IDLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    mf_stall |-> busy); // R8
  AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FIX && is_div && dz) |=> (lo_q == '1)); // R5
endmodule

// File: tb/hilo_muldiv_tb.sv
module hilo_muldiv_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [5:0] func = '0;
  logic [31:0] rs_val = '0, rt_val = '0;
  logic mf_req = 1'b0;
  logic [5:0] mf_func = '0;
  logic [31:0] mf_data;
  logic mf_stall, busy;
  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_hi = '0, exp_lo = '0;

  always #10 clk = ~clk;

  hilo_muldiv u_dut (.clk(clk), .rst_n(rst_n), .start(start), .func(func),
    .rs_val(rs_val), .rt_val(rt_val), .mf_req(mf_req), .mf_func(mf_func),
    .mf_data(mf_data), .mf_stall(mf_stall), .busy(busy));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic string tag(input logic [5:0] f, input logic [31:0] b);
    if (f[1] && b == 0) return "R5";
    case (f[1:0])
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic model(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q, r;
    logic [63:0] p;
    if (f[1:0] == 2'd0) begin
      p = 64'($signed(a) * $signed(b));
      p = longint'($signed(a)) * longint'($signed(b));
      exp_hi = p[63:32]; exp_lo = p[31:0];
    end else if (f[1:0] == 2'd1) begin
      p = {32'b0, a} * {32'b0, b};
      exp_hi = p[63:32]; exp_lo = p[31:0];
    end else if (b == 0) begin
      exp_lo = '1; exp_hi = a;
    end else if (f[1:0] == 2'd2) begin
      sa = longint'($signed(a)); sb = longint'($signed(b));
      q = sa / sb; r = sa % sb;
      exp_lo = q[31:0]; exp_hi = r[31:0];
    end else begin
      exp_lo = a / b; exp_hi = a % b;
    end
  endtask

  task automatic read_both(input string req);
    mf_func = 6'b010000; #1; chk(req, mf_data, exp_hi);
    mf_func = 6'b010010; #1; chk(req, mf_data, exp_lo);
  endtask

  task automatic run_op(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b,
                        input bit poke);
    int len;
    logic [31:0] old_hi, old_lo;
    string t;
    old_hi = exp_hi; old_lo = exp_lo;
    t = tag(f, b);
    @(negedge clk);
    start = 1'b1; func = f; rs_val = a; rt_val = b;
    @(negedge clk);
    start = 1'b0; rs_val = $urandom; rt_val = $urandom;
    len = 0;
    while (busy && len < 100) begin
      len++;
      if (poke && len == 5) begin
        start = 1'b1; func = 6'b011001;
        mf_req = 1'b1; #1;
        chk("R8", {31'b0, mf_stall}, 32'd1);
        mf_func = 6'b010000; #1; chk("R8", mf_data, old_hi);
        mf_func = 6'b010010; #1; chk("R8", mf_data, old_lo);
      end
      @(negedge clk);
      start = 1'b0; mf_req = 1'b0;
    end
    chk("R6", len, 33);
    model(f, a, b);
    read_both(t);
    if (poke) begin
      #1; chk("R7", {31'b0, busy}, 32'd0);
      mf_req = 1'b1; #1; chk("R8", {31'b0, mf_stall}, 32'd0); mf_req = 1'b0;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", {31'b0, busy}, 32'd0);
    read_both("R11");
    mf_func = 6'b000111; #1; chk("R9", mf_data, 32'd0);
    // directed corners
    run_op(6'b011000, 32'hFFFF_FFFF, 32'h0000_0007, 1'b0);  // R1 negative
    run_op(6'b011000, 32'h8000_0000, 32'h8000_0000, 1'b0);  // R1
    run_op(6'b011001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);  // R2
    run_op(6'b011010, 32'hFFFF_FFF9, 32'h0000_0002, 1'b0);  // R3 -7/2
    run_op(6'b011010, 32'h0000_0007, 32'hFFFF_FFFE, 1'b0);  // R3 7/-2
    run_op(6'b011010, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);  // R3 min/-1
    run_op(6'b011011, 32'hFFFF_FFFF, 32'h0000_0010, 1'b0);  // R4
    run_op(6'b011010, 32'hFFFF_FF00, 32'h0000_0000, 1'b0);  // R5 signed
    run_op(6'b011011, 32'h1234_5678, 32'h0000_0000, 1'b1);  // R5 unsigned, R7/R8 poke
    // R10: bad function code
    @(negedge clk);
    start = 1'b1; func = 6'b100000; rs_val = 32'd5; rt_val = 32'd6;
    @(negedge clk);
    start = 1'b0;
    chk("R10", {31'b0, busy}, 32'd0);
    read_both("R10");
    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [5:0] f;
      f = {4'b0110, 2'($urandom_range(0, 3))};
      run_op(f, $urandom, (i % 5 == 0) ? 32'($urandom_range(0, 3)) : $urandom, (i % 7 == 0));
    end
    summary();
  end
endmodule